// File: doc/BRIEF.md
# Receive Address Field CAM Strobe Generator

This block sits on a byte-wide receive stream (one byte per clock, with a start-of-frame marker and a byte-valid qualifier). It drives the side-band signals that an external address recognition memory needs. The first byte after start-of-frame is the frame-control byte. Bit 6 of that byte, the address-length bit, selects between long addresses (6 bytes each) and short addresses (2 bytes each). The destination address field follows the frame-control byte, and the source address field follows the destination field.

The block re-times the byte stream by one register stage. Because of this, it can raise a one-cycle load strobe in the output cycle just before the first byte of each address field appears. It marks destination bytes with a field indicator and presents the most recent address-length bit. Frames are dropped on a primary abort, or on a secondary abort when that abort is enabled, and the block then flags end of data downstream. An optional active-low external match input can be passed through as the match result.

Top module: `cam_strobe_gen`

## Requirements
- R1: Every output is registered. A byte accepted at the inputs appears on `out_data`/`out_valid` exactly one clock later. After reset all outputs are 0.
- R2: A valid byte with `rx_sof`=1 is a frame-control byte. One clock later `addr_long` equals that byte's bit 6, and it holds that value until the next accepted frame-control byte.
- R3: When the address-length bit is 1, each address field is 6 bytes long. When it is 0, each address field is 2 bytes long.
- R4: `cam_load` is high for one clock in the output cycle of the frame-control byte, which is the cycle just before the first destination byte.
- R5: `cam_load` is high for one clock in the output cycle of the last destination byte, which is the cycle just before the first source byte.
- R6: `da_sel` is high exactly in the output cycles of destination address bytes, and low for the frame-control byte, source bytes, body bytes and idle cycles.
- R7: A token is a frame-control byte with bit 7 = 1 and bits 5..0 = 0. A token updates `addr_long` but produces no `cam_load` and no `da_sel`.
- R8: While `abort_in` is high, the current byte is dropped and parsing returns to idle. `eod` pulses one clock later if a frame was open. Later bytes without `rx_sof` are dropped.
- R9: When `abort2_en`=1, `abort2_in` behaves exactly like `abort_in`. When `abort2_en`=0, `abort2_in` has no effect.
- R10: When `match_en`=1, `addr_match` is the inverse of `match_n`, registered one clock. When `match_en`=0, `addr_match` stays 0.
- R11: A start-of-frame byte at any point, including inside an address field, restarts parsing from the frame-control byte. An abort in the same cycle takes priority over the start-of-frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | Marks the frame-control byte |
| abort_in | input | 1 | Primary abort request |
| abort2_in | input | 1 | Secondary abort request |
| abort2_en | input | 1 | Enables the secondary abort |
| match_en | input | 1 | Enables the external match input |
| match_n | input | 1 | External match, active low |
| out_data | output | 8 | Re-timed byte |
| out_valid | output | 1 | Re-timed byte qualifier |
| cam_load | output | 1 | One-cycle load strobe before each address field |
| da_sel | output | 1 | High on destination address bytes |
| addr_long | output | 1 | Last address-length bit seen |
| eod | output | 1 | End-of-data pulse after an abort |
| addr_match | output | 1 | Match result |

## Verification
The bench sends a frame for every one of the 256 frame-control values. It checks the strobe position, the destination window and the address length for each, which catches a field-length decode that uses the wrong bit and a strobe that lands one byte late. It also aborts at every byte position of short and long frames through each abort path. A design that forgot the enable on the secondary abort would drop frames it should keep. A design that let the start-of-frame byte beat the abort would forward a byte it should drop. Restarts inside each address byte check that a stale byte counter does not shift the source strobe of the next frame.

// File: rtl/cam_pkg.sv
// Shared types for the receive address strobe generator.
package cam_pkg;
    // Parser position between bytes.
    typedef enum logic [1:0] {
        FLD_IDLE = 2'd0,
        FLD_DA   = 2'd1,
        FLD_SA   = 2'd2,
        FLD_BODY = 2'd3
    } fld_state_t;

    // Classification of the byte currently at the inputs.
    typedef enum logic [2:0] {
        BYTE_NONE = 3'd0,
        BYTE_FC   = 3'd1,
        BYTE_DA   = 3'd2,
        BYTE_SA   = 3'd3,
        BYTE_BODY = 3'd4
    } byte_kind_t;
endpackage

// File: rtl/cam_fc_decoder.sv
// Decodes a frame-control byte: the address-length bit and token detection.
// Assumes that a token has the top bit set and every bit below the length
// bit clear.
module cam_fc_decoder #(
    parameter int DATA_W   = 8,
    parameter int LBIT_POS = 6
) (
    input  logic [DATA_W-1:0] fc,
    output logic              is_long,
    output logic              is_token
);
    localparam int LOW_W = LBIT_POS;

    // Pull the length bit and the token pattern out of the byte.
    always_comb begin
        is_long  = fc[LBIT_POS];
        is_token = fc[DATA_W-1] && (fc[LOW_W-1:0] == '0);
    end
endmodule

// File: rtl/cam_field_tracker.sv
// Tracks which field the current input byte belongs to and predicts the
// load strobe for the output stage. Assumes that the address bytes arrive
// with rx_valid held high. An abort overrides every other input.
module cam_field_tracker
    import cam_pkg::*;
#(
    parameter int LONG_BYTES  = 6,
    parameter int SHORT_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_ok,
    input  logic       sof,
    input  logic       abort,
    input  logic       is_long,
    input  logic       is_token,
    output byte_kind_t kind,
    output logic       strobe_next,
    output logic       frame_open
);
    localparam int CNT_W = $clog2(LONG_BYTES + 1);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LONG_BYTES);
    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SHORT_BYTES);

    fld_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_q, len_d;
    logic             last_byte;

    assign last_byte  = (cnt_q == len_q - 1'b1);
    assign frame_open = (st_q != FLD_IDLE);

    // Classify the byte and work out the next parser position.
    always_comb begin
        st_d        = st_q;
        cnt_d       = cnt_q;
        len_d       = len_q;
        kind        = BYTE_NONE;
        strobe_next = 1'b0;
        if (abort) begin
            st_d  = FLD_IDLE;
            cnt_d = '0;
        end else if (byte_ok) begin
            if (sof) begin
                kind  = BYTE_FC;
                cnt_d = '0;
                len_d = is_long ? LEN_L : LEN_S;
                if (is_token) begin
                    st_d = FLD_BODY;
                end else begin
                    st_d        = FLD_DA;
                    strobe_next = 1'b1;
                end
            end else begin
                case (st_q)
                    FLD_DA: begin
                        kind = BYTE_DA;
                        if (last_byte) begin
                            st_d        = FLD_SA;
                            cnt_d       = '0;
                            strobe_next = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    FLD_SA: begin
                        kind = BYTE_SA;
                        if (last_byte) begin
                            st_d  = FLD_BODY;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    FLD_BODY: kind = BYTE_BODY;
                    default:  kind = BYTE_NONE;
                endcase
            end
        end
    end

    // Hold the parser position, byte count and field length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FLD_IDLE;
            cnt_q <= '0;
            len_q <= LEN_S;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            len_q <= len_d;
        end
    end
endmodule

// File: rtl/cam_out_stage.sv
// Output register stage. It delays the byte stream by one clock so that the
// strobe computed for byte N lines up with byte N at the outputs.
module cam_out_stage
    import cam_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              byte_ok,
    input  logic              sof,
    input  logic              abort,
    input  byte_kind_t        kind,
    input  logic              strobe_next,
    input  logic              is_long,
    input  logic              frame_open,
    input  logic              match_en,
    input  logic              match_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              cam_load,
    output logic              da_sel,
    output logic              addr_long,
    output logic              eod,
    output logic              addr_match
);
    // Register every side-band output from the tracker results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_valid  <= 1'b0;
            cam_load   <= 1'b0;
            da_sel     <= 1'b0;
            addr_long  <= 1'b0;
            eod        <= 1'b0;
            addr_match <= 1'b0;
        end else begin
            out_data   <= data_in;
            out_valid  <= byte_ok && !abort && (kind != BYTE_NONE);
            cam_load   <= strobe_next;
            da_sel     <= (kind == BYTE_DA);
            if (byte_ok && sof && !abort) begin
                addr_long <= is_long;
            end
            eod        <= abort && frame_open;
            addr_match <= match_en && !match_n;
        end
    end
endmodule

// File: rtl/cam_strobe_gen.sv
// Top of the receive address strobe generator. It combines the two abort
// sources and connects the decoder, the tracker and the output stage.
module cam_strobe_gen
    import cam_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LBIT_POS    = 6,
    parameter int LONG_BYTES  = 6,
    parameter int SHORT_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              abort_in,
    input  logic              abort2_in,
    input  logic              abort2_en,
    input  logic              match_en,
    input  logic              match_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              cam_load,
    output logic              da_sel,
    output logic              addr_long,
    output logic              eod,
    output logic              addr_match
);
    logic       abort_eff;
    logic       fc_long;
    logic       fc_token;
    byte_kind_t kind;
    logic       strobe_next;
    logic       frame_open;

    assign abort_eff = abort_in || (abort2_in && abort2_en);

    cam_fc_decoder #(.DATA_W(DATA_W), .LBIT_POS(LBIT_POS)) dec_i (
        .fc       (rx_data),
        .is_long  (fc_long),
        .is_token (fc_token)
    );

    cam_field_tracker #(.LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)) trk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_ok     (rx_valid),
        .sof         (rx_sof),
        .abort       (abort_eff),
        .is_long     (fc_long),
        .is_token    (fc_token),
        .kind        (kind),
        .strobe_next (strobe_next),
        .frame_open  (frame_open)
    );

    cam_out_stage #(.DATA_W(DATA_W)) out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (rx_data),
        .byte_ok     (rx_valid),
        .sof         (rx_sof),
        .abort       (abort_eff),
        .kind        (kind),
        .strobe_next (strobe_next),
        .is_long     (fc_long),
        .frame_open  (frame_open),
        .match_en    (match_en),
        .match_n     (match_n),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .cam_load    (cam_load),
        .da_sel      (da_sel),
        .addr_long   (addr_long),
        .eod         (eod),
        .addr_match  (addr_match)
    );
endmodule

// File: rtl/cam_strobe_gen_chk.sv
// Port-level temporal checks for cam_strobe_gen, attached through bind.
module cam_strobe_gen_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_sof,
    input logic              abort_in,
    input logic              abort2_in,
    input logic              abort2_en,
    input logic              match_en,
    input logic              match_n,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              cam_load,
    input logic              da_sel,
    input logic              addr_long,
    input logic              eod,
    input logic              addr_match
);
    AST_DA_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        da_sel |-> out_valid); // R6
    AST_LONG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_sof) |=> $stable(addr_long)); // R2
    AST_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !match_en |=> !addr_match); // R10
    AST_EOD_FROM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_in || (abort2_in && abort2_en)) |=> !eod); // R8
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort_in |=> (!out_valid && !cam_load && !da_sel)); // R8
    AST_ABORT2_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_in && !abort2_en && rx_valid && rx_sof) |=> out_valid); // R9
endmodule

bind cam_strobe_gen cam_strobe_gen_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cam_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module cam_strobe_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0, rx_sof = 1'b0;
    logic       abort_in = 1'b0, abort2_in = 1'b0, abort2_en = 1'b0;
    logic       match_en = 1'b0, match_n = 1'b1;
    logic [7:0] out_data;
    logic       out_valid, cam_load, da_sel, addr_long, eod, addr_match;

    int n_checks = 0;
    int n_fail = 0;
    bit mdl_open = 1'b0;
    bit mdl_long = 1'b0;

    always #5 clk = ~clk;

    cam_strobe_gen dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, cross one rising edge, and return at the
    // falling edge where the registered outputs can be sampled.
    task automatic step(input logic [7:0] d, input logic v, input logic s,
                        input logic a1, input logic a2);
        rx_data = d; rx_valid = v; rx_sof = s; abort_in = a1; abort2_in = a2;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; abort_in = 1'b0; abort2_in = 1'b0;
    endtask

    // Send one frame. abort_pos < 0 means no abort; sel 0 = primary abort,
    // 1 = enabled secondary, 2 = disabled secondary. stop_at truncates the frame.
    task automatic send_frame(input logic [7:0] fc, input int body_len,
                              input int abort_pos, input int sel, input int stop_at);
        bit lng = fc[6];
        bit tok = fc[7] && (fc[5:0] == 6'd0);
        int n = lng ? 6 : 2;
        int total = (tok ? 1 : 1 + 2 * n) + body_len;
        abort2_en = (sel == 1);
        for (int k = 0; k < total; k++) begin
            logic [7:0] b = (k == 0) ? fc : 8'(8'h10 + k) ^ fc;
            bit ab = (k == abort_pos);
            bit eff = ab && (sel != 2);
            if (stop_at >= 0 && k >= stop_at) break;
            step(b, 1'b1, k == 0, ab && sel == 0, ab && sel != 0);
            if (eff) begin
                chk("R8 abort drops byte", out_valid, 0);
                chk("R11 abort beats sof", cam_load | da_sel, 0);
                chk("R8 eod after abort", eod, mdl_open);
                chk("R8 addr_long untouched", addr_long, mdl_long);
                mdl_open = 1'b0;
                step(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
                chk("R8 later bytes dropped", out_valid, 0);
                chk("R8 eod single pulse", eod, 0);
                chk("R6 no da after abort", da_sel, 0);
                abort2_en = 1'b0;
                return;
            end
            if (k == 0) begin mdl_open = 1'b1; mdl_long = lng; end
            chk("R1 valid latency", out_valid, 1);
            chk("R1 data latency", out_data, b);
            chk("R2 addr_long", addr_long, lng);
            if (tok) chk("R7 token no strobe", cam_load, 0);
            else if (k == 0) chk("R4 load before DA", cam_load, 1);
            else if (k == n) chk("R5 load before SA", cam_load, 1);
            else chk("R3 no strobe elsewhere", cam_load, 0);
            if (tok) chk("R7 token no da", da_sel, 0);
            else chk("R6 da window", da_sel, (k >= 1 && k <= n));
            chk(ab ? "R9 disabled abort2 ignored" : "R8 no eod", eod, 0);
        end
        abort2_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {out_valid, cam_load, da_sel, addr_long, eod, addr_match}, 0);
        // All frame-control values, with body lengths varying from 0 to 2.
        for (int f = 0; f < 256; f++) send_frame(8'(f), f % 3, -1, 0, -1);
        // Aborts at every position, through each path.
        for (int l = 0; l < 2; l++)
            for (int sel = 0; sel < 3; sel++)
                for (int p = 0; p < (l ? 14 : 6); p++) begin
                    logic [7:0] fc = l ? 8'h51 : 8'h11;
                    send_frame(fc, 1, p, sel, -1);
                end
        // Restarts inside the address fields.
        for (int l = 0; l < 2; l++)
            for (int s = 1; s <= (l ? 12 : 4); s++) begin
                send_frame(l ? 8'h52 : 8'h12, 0, -1, 0, s);
                send_frame(l ? 8'h13 : 8'h53, 1, -1, 0, -1);
            end
        // External match input.
        for (int m = 0; m < 4; m++) begin
            match_en = m[1]; match_n = m[0];
            step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R10 match", addr_match, (m[1] && !m[0]));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule